// File: doc/BRIEF.md
# Receive Descriptor and Status Ring Engine

This block manages the receive side of a packet interface that hands frames to memory through two circular rings. Software fills a descriptor ring with free buffers and keeps a status ring where results are reported. It tells the engine how many new entries it has made available in each ring by writing grant counts. The engine holds one credit counter per ring. For each frame that ends, it takes the descriptor at its current descriptor pointer. It then writes a two-word status entry at its current status pointer, advances both pointers and spends one credit from each counter.

The receive MAC, address filtering and CRC checking sit outside the block. A frame reaches the engine as a one-cycle end-of-frame pulse carrying the byte length, five error flags and a flag that says whether the CRC is counted in that length. The engine reads the buffer index from descriptor word 1 at the descriptor pointer and echoes it into the status entry. When either credit counter is empty, or the engine is still writing the previous entry, the frame is dropped and the overrun counter advances. A receive interrupt bit is raised each time a status entry is completed and stays set until it is cleared.

Top module: `rx_ring_engine`

## Requirements
- R1: `rx_active` follows `rx_en` one cycle later. While `rx_en` is low, both pointers return to their ring bases and both credit counters read zero. While `rx_active` is low, frames are ignored: nothing is written and the overrun count does not change.
- R2: A grant write adds its count to the matching credit counter at the next clock edge.
- R3: A frame accepted at edge T makes `stat_wr_en` high after T, with status word 0 at the status pointer. After T+1 it presents word 1 at the status pointer plus 4. After T+2 `stat_wr_en` is low again.
- R4: Status word 0 has these fields: bit 31 processed, always 1. Bit 30 good. Bit 29 end of frame, always 1. Bit 28 end of buffer, always 1. Bits 27:21 are zero. Bits 20:16 carry the error flags in the order overrun, framing, runt, extra data, CRC error (`frm_err[4:0]` maps to bits 20:16). Bit 15 is the CRC-included flag. Bits 14:0 are zero.
- R5: Status word 1 has bit 31 set as processed. Bits 30:16 hold the buffer index taken from bits 30:16 of `desc_word1`. Bits 15:0 hold the frame length. The not-start-of-frame bit (31) and the buffer length (15:0) of the descriptor word are ignored.
- R6: A length above MAX_LEN (2044) sets the extra-data flag, bit 17. The good bit is 1 only when bits 20:16 are all zero.
- R7: One cycle after word 1 is written, both pointers have advanced by 8 bytes and both credit counters have dropped by one (plus any grant made in the same cycle).
- R8: A pointer whose next value would reach or pass its base plus its ring byte length returns to its base instead.
- R9: A frame that arrives while either credit counter is zero is dropped. Nothing is written, the pointers and credits are unchanged, and `ovr_cnt` increases by one.
- R10: A frame that arrives while a status entry is still being written is dropped and counted in `ovr_cnt`. The entry already in progress is unaffected.
- R11: `int_sts[2]` is set in the cycle after a status entry completes and stays set until an `irq_clr` pulse. A completion in the same cycle as `irq_clr` wins. The other `int_sts` bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable |
| desc_base | input | AW | Descriptor ring base byte address |
| desc_ring_bytes | input | LW | Descriptor ring length in bytes |
| stat_base | input | AW | Status ring base byte address |
| stat_ring_bytes | input | LW | Status ring length in bytes |
| desc_grant_we | input | 1 | Descriptor grant strobe |
| desc_grant | input | CW | Number of descriptors granted |
| stat_grant_we | input | 1 | Status slot grant strobe |
| stat_grant | input | CW | Number of status slots granted |
| frm_valid | input | 1 | End-of-frame pulse |
| frm_len | input | 16 | Frame length in bytes |
| frm_err | input | 5 | Overrun, framing, runt, extra data, CRC error (MSB first) |
| frm_crc_incl | input | 1 | CRC counted in length |
| desc_word1 | input | 32 | Descriptor word 1 at `desc_addr` |
| irq_clr | input | 1 | Clears the receive interrupt bit |
| rx_active | output | 1 | Receive path active |
| desc_addr | output | AW | Current descriptor pointer |
| stat_wr_en | output | 1 | Status write strobe |
| stat_wr_addr | output | AW | Status write byte address |
| stat_wr_data | output | 32 | Status write data |
| int_sts | output | 4 | Interrupt status, bit 2 = frames received |
| desc_credit | output | CW | Descriptor credits |
| stat_credit | output | CW | Status slot credits |
| ovr_cnt | output | OCW | Dropped frame count |

## Verification
The hardest case to reach from the ports is a frame that arrives in the middle of a two-cycle status write while credits remain. In that case the drop comes only from the busy window and not from an empty counter. The bench holds the end-of-frame pulse high for two edges with ample credits. It then confirms that exactly one entry was spent and that the overrun count advanced. Random traffic keeps the descriptor ring smaller than the status ring and grants credits sparingly. Because of this, the two rings wrap at different moments, and empty credit counters occur among accepted frames.

// File: rtl/rx_ring_engine.sv
module rx_ring_engine #(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int CW = 8,
  parameter int OCW = 16,
  parameter int MAX_LEN = 2044
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rx_en,
  input  logic [AW-1:0]  desc_base,
  input  logic [LW-1:0]  desc_ring_bytes,
  input  logic [AW-1:0]  stat_base,
  input  logic [LW-1:0]  stat_ring_bytes,
  input  logic           desc_grant_we,
  input  logic [CW-1:0]  desc_grant,
  input  logic           stat_grant_we,
  input  logic [CW-1:0]  stat_grant,
  input  logic           frm_valid,
  input  logic [15:0]    frm_len,
  input  logic [4:0]     frm_err,
  input  logic           frm_crc_incl,
  input  logic [31:0]    desc_word1,
  input  logic           irq_clr,
  output logic           rx_active,
  output logic [AW-1:0]  desc_addr,
  output logic           stat_wr_en,
  output logic [AW-1:0]  stat_wr_addr,
  output logic [31:0]    stat_wr_data,
  output logic [3:0]     int_sts,
  output logic [CW-1:0]  desc_credit,
  output logic [CW-1:0]  stat_credit,
  output logic [OCW-1:0] ovr_cnt
);
  localparam logic [AW-1:0] ENTRY_BYTES = AW'(8);

  typedef enum logic [1:0] {S_IDLE, S_W0, S_W1} st_t;
  st_t state;

  logic [AW-1:0] d_cur, s_cur;
  logic [31:0]   w0_q, w1_q;
  logic          irq_q;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] cur,
                                         input logic [AW-1:0] base,
                                         input logic [LW-1:0] len);
    logic [AW-1:0] n;
    n = cur + ENTRY_BYTES;
    return (n >= base + AW'(len)) ? base : n;
  endfunction

  wire accept = frm_valid && rx_active && state == S_IDLE &&
                desc_credit != '0 && stat_credit != '0;
  wire drop   = frm_valid && rx_active && !accept;
  wire done   = state == S_W1;

  wire       too_long = frm_len > 16'(MAX_LEN);
  wire [4:0] flags    = {frm_err[4:2], frm_err[1] | too_long, frm_err[0]};
  wire       good     = flags == 5'd0;
  wire [31:0] w0_d    = {1'b1, good, 2'b11, 7'd0, flags, frm_crc_incl, 15'd0};
  wire [31:0] w1_d    = {1'b1, desc_word1[30:16], frm_len};

  assign desc_addr    = d_cur;
  assign stat_wr_en   = state != S_IDLE;
  assign stat_wr_addr = done ? s_cur + AW'(4) : s_cur;
  assign stat_wr_data = done ? w1_q : w0_q;
  assign int_sts      = {1'b0, irq_q, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_active <= 1'b0;
      state     <= S_IDLE;
      w0_q      <= '0;
      w1_q      <= '0;
    end else begin
      rx_active <= rx_en;
      if (!rx_en) state <= S_IDLE;
      else begin
        case (state)
          S_IDLE: if (accept) begin
            state <= S_W0;
            w0_q  <= w0_d;
            w1_q  <= w1_d;
          end
          S_W0:    state <= S_W1;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_cur       <= '0;
      s_cur       <= '0;
      desc_credit <= '0;
      stat_credit <= '0;
    end else if (!rx_en) begin
      d_cur       <= desc_base;
      s_cur       <= stat_base;
      desc_credit <= '0;
      stat_credit <= '0;
    end else begin
      if (done) begin
        d_cur <= step(d_cur, desc_base, desc_ring_bytes);
        s_cur <= step(s_cur, stat_base, stat_ring_bytes);
      end
      desc_credit <= desc_credit + (desc_grant_we ? desc_grant : '0) - CW'(done);
      stat_credit <= stat_credit + (stat_grant_we ? stat_grant : '0) - CW'(done);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      ovr_cnt <= '0;
    end else begin
      if (done) irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
      if (drop) ovr_cnt <= ovr_cnt + OCW'(1);
    end
  end
endmodule

// File: rtl/rx_ring_engine_chk.sv
module rx_ring_engine_chk #(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          rx_active,
  input logic [AW-1:0] stat_base,
  input logic [LW-1:0] stat_ring_bytes,
  input logic          desc_grant_we,
  input logic [CW-1:0] desc_credit,
  input logic          stat_wr_en,
  input logic [AW-1:0] stat_wr_addr,
  input logic [31:0]   stat_wr_data,
  input logic [3:0]    int_sts
);
  p_inactive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_wr_en) |-> $past(rx_active));

  p_word_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_wr_en) && rx_en |=> stat_wr_en && stat_wr_addr == $past(stat_wr_addr) + AW'(4));

  p_processed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr_en |-> stat_wr_data[31]);

  p_credit_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && $past(rx_en) && !$past(desc_grant_we) && $fell(stat_wr_en)
      |-> desc_credit == $past(desc_credit) - CW'(1));

  p_in_ring_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr_en |-> stat_wr_addr >= stat_base && stat_wr_addr < stat_base + AW'(stat_ring_bytes));

  p_irq_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_sts[2]) |-> $past(stat_wr_en));
endmodule

bind rx_ring_engine rx_ring_engine_chk #(.AW(AW), .LW(LW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_active(rx_active),
  .stat_base(stat_base), .stat_ring_bytes(stat_ring_bytes),
  .desc_grant_we(desc_grant_we), .desc_credit(desc_credit),
  .stat_wr_en(stat_wr_en), .stat_wr_addr(stat_wr_addr),
  .stat_wr_data(stat_wr_data), .int_sts(int_sts));

// File: tb/tb_rx_ring_engine.sv
module tb_rx_ring_engine;
  localparam logic [31:0] DB = 32'h0000_1000;
  localparam logic [31:0] SB = 32'h0000_2000;
  localparam int DENT = 4;
  localparam int SENT = 6;

  logic clk = 0, rst_n = 0, rx_en = 0;
  logic desc_grant_we = 0, stat_grant_we = 0, frm_valid = 0, frm_crc_incl = 0, irq_clr = 0;
  logic [7:0] desc_grant = 0, stat_grant = 0;
  logic [15:0] frm_len = 0;
  logic [4:0] frm_err = 0;
  logic [31:0] desc_word1;
  logic rx_active, stat_wr_en;
  logic [31:0] desc_addr, stat_wr_addr, stat_wr_data;
  logic [3:0] int_sts;
  logic [7:0] desc_credit, stat_credit;
  logic [15:0] ovr_cnt;

  always #10 clk = ~clk;

  assign desc_word1 = {1'b1, 15'((desc_addr - DB) >> 3) + 15'h0100, 16'h0800};

  rx_ring_engine dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
    .desc_base(DB), .desc_ring_bytes(16'(DENT*8)),
    .stat_base(SB), .stat_ring_bytes(16'(SENT*8)),
    .desc_grant_we(desc_grant_we), .desc_grant(desc_grant),
    .stat_grant_we(stat_grant_we), .stat_grant(stat_grant),
    .frm_valid(frm_valid), .frm_len(frm_len), .frm_err(frm_err),
    .frm_crc_incl(frm_crc_incl), .desc_word1(desc_word1), .irq_clr(irq_clr),
    .rx_active(rx_active), .desc_addr(desc_addr), .stat_wr_en(stat_wr_en),
    .stat_wr_addr(stat_wr_addr), .stat_wr_data(stat_wr_data), .int_sts(int_sts),
    .desc_credit(desc_credit), .stat_credit(stat_credit), .ovr_cnt(ovr_cnt));

  int n_chk = 0, n_fail = 0;
  int d_ent = 0, s_ent = 0, dcr = 0, scr = 0, ovr = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_w0(input logic [15:0] len, input logic [4:0] err, input logic crc);
    logic [4:0] f;
    f = err | ((len > 16'd2044) ? 5'b00010 : 5'b00000);
    return {1'b1, f == 5'd0, 1'b1, 1'b1, 7'd0, f, crc, 15'd0};
  endfunction

  task automatic grant(input int d, input int s);
    @(negedge clk);
    desc_grant_we = d > 0; desc_grant = 8'(d);
    stat_grant_we = s > 0; stat_grant = 8'(s);
    @(negedge clk);
    desc_grant_we = 0; stat_grant_we = 0;
    dcr += d; scr += s;
    chk("R2 desc credit", 32'(desc_credit), 32'(dcr));
    chk("R2 stat credit", 32'(stat_credit), 32'(scr));
  endtask

  task automatic send(input logic [15:0] len, input logic [4:0] err, input logic crc);
    bit ok;
    ok = dcr > 0 && scr > 0;
    @(negedge clk);
    frm_valid = 1; frm_len = len; frm_err = err; frm_crc_incl = crc;
    @(negedge clk);
    frm_valid = 0;
    if (ok) begin
      chk("R3 w0 strobe", 32'(stat_wr_en), 1);
      chk("R3 w0 addr", stat_wr_addr, SB + 32'(s_ent*8));
      chk("R4 R6 w0 data", stat_wr_data, exp_w0(len, err, crc));
      @(negedge clk);
      chk("R3 w1 addr", stat_wr_addr, SB + 32'(s_ent*8) + 4);
      chk("R5 w1 data", stat_wr_data, {1'b1, 15'(d_ent) + 15'h0100, len});
      @(negedge clk);
      d_ent = (d_ent + 1) % DENT; s_ent = (s_ent + 1) % SENT; dcr--; scr--;
      chk("R3 strobe low", 32'(stat_wr_en), 0);
      chk("R7 R8 desc ptr", desc_addr, DB + 32'(d_ent*8));
      chk("R7 desc credit", 32'(desc_credit), 32'(dcr));
      chk("R7 stat credit", 32'(stat_credit), 32'(scr));
      chk("R11 irq set", 32'(int_sts), 32'h4);
    end else begin
      ovr++;
      chk("R9 no write", 32'(stat_wr_en), 0);
      @(negedge clk);
      chk("R9 no write", 32'(stat_wr_en), 0);
      chk("R9 ovr count", 32'(ovr_cnt), 32'(ovr));
      chk("R9 credits kept", 32'(desc_credit), 32'(dcr));
      chk("R9 ptr kept", desc_addr, DB + 32'(d_ent*8));
    end
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    chk("R1 reset active", 32'(rx_active), 0);
    chk("R1 reset write", 32'(stat_wr_en), 0);
    chk("R11 reset irq", 32'(int_sts), 0);
    chk("R1 reset credit", 32'(desc_credit), 0);
    rst_n = 1;
    @(negedge clk); rx_en = 1;
    @(negedge clk);
    chk("R1 active", 32'(rx_active), 1);
    chk("R1 desc base", desc_addr, DB);

    send(16'd60, 5'd0, 1'b0);
    grant(3, 0);
    send(16'd60, 5'd0, 1'b0);
    grant(0, 9);
    send(16'd64, 5'd0, 1'b1);
    send(16'd2045, 5'd0, 1'b0);
    send(16'd2044, 5'b00001, 1'b1);
    send(16'd2044, 5'd0, 1'b0);

    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
    chk("R11 irq cleared", 32'(int_sts), 0);

    for (int i = 0; i < 60; i++) begin
      if (($urandom % 3) == 0 && dcr < 40 && scr < 40)
        grant($urandom % 3, $urandom % 3);
      send(16'($urandom % 2100), (($urandom % 4) == 0) ? 5'($urandom) : 5'd0, 1'($urandom));
    end

    grant(2, 2);
    @(negedge clk);
    frm_valid = 1; frm_len = 16'd100; frm_err = 0; frm_crc_incl = 0;
    repeat (2) @(negedge clk);
    frm_valid = 0;
    chk("R10 entry in progress", stat_wr_data, {1'b1, 15'(d_ent) + 15'h0100, 16'd100});
    repeat (2) @(negedge clk);
    ovr++; dcr--; scr--;
    d_ent = (d_ent + 1) % DENT; s_ent = (s_ent + 1) % SENT;
    chk("R10 busy drop counted", 32'(ovr_cnt), 32'(ovr));
    chk("R10 one credit used", 32'(desc_credit), 32'(dcr));
    chk("R10 one entry", desc_addr, DB + 32'(d_ent*8));

    @(negedge clk); rx_en = 0;
    repeat (2) @(negedge clk);
    chk("R1 inactive", 32'(rx_active), 0);
    chk("R1 ptr to base", desc_addr, DB);
    chk("R1 credit cleared", 32'(stat_credit), 0);
    frm_valid = 1;
    @(negedge clk); frm_valid = 0;
    @(negedge clk);
    chk("R1 ignored write", 32'(stat_wr_en), 0);
    chk("R1 ignored ovr", 32'(ovr_cnt), 32'(ovr));

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule